// File: doc/BRIEF.md
# Self-Shrinking Keystream Generator

This block produces a keystream from a single linear feedback shift register whose output bits are thinned out by a data-dependent selection rule. The register advances by one step in every enabled clock cycle. Its output bits are gathered into fresh, non-overlapping groups, and each completed group yields one kept bit or none. Because some groups yield nothing, the stream leaves the block at an irregular rate, and a one-cycle valid strobe marks every kept bit.

There are two selection modes. In the two-bit mode the first bit of a pair decides whether the second bit is kept. In the three-bit mode the XOR of the first two bits of a triple decides whether the third bit is kept. A seed port replaces the register state and restarts the grouping. A seed of all zeros is refused because it would lock the register. The register length and feedback taps are parameters.

Top module: `shrink_keygen`

## Requirements
- R1: Each cycle with `enable` high and `seed_load` low advances the register by one step. The step consumes the current MSB as the group bit, shifts the state left by one, and puts the parity of `(state & TAPS)` into bit 0. TAPS must have its MSB set, so a nonzero state never becomes zero.
- R2: With `mode` = 0 (two-bit mode), bits are taken in pairs (b0, b1). b1 is emitted when b0 = 1 and discarded when b0 = 0.
- R3: With `mode` = 1 (three-bit mode), bits are taken in triples (a0, a1, a2). a2 is emitted when a0 XOR a1 = 1 and discarded when it is 0.
- R4: `ks_valid` is high for exactly one cycle, the cycle after the clock edge that consumed the last bit of a group whose rule holds. `ks_bit` then carries the kept bit. `ks_valid` is low in every other cycle.
- R5: `mode` is sampled on the step that consumes a group's first bit. A change of `mode` part-way through a group affects only the next group.
- R6: `seed_load` with a nonzero `seed` loads the state and restarts the grouping at a first bit. No step happens in that cycle, and `ks_valid` is low in the following cycle.
- R7: `seed_load` with an all-zero `seed` is refused. The state and the grouping position are unchanged, and no step happens in that cycle.
- R8: With `enable` low and no load, the state and the grouping are held and `ks_valid` is low.
- R9: After reset the state equals `RST_SEED`, grouping starts at a first bit, and `ks_valid` and `ks_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_load | input | 1 | Load `seed` into the register this cycle |
| seed | input | LEN | Seed value; all zeros is refused |
| enable | input | 1 | Advance the register one step this cycle |
| mode | input | 1 | 0 = two-bit selection, 1 = three-bit selection |
| ks_bit | output | 1 | Kept keystream bit |
| ks_valid | output | 1 | One-cycle strobe marking a kept bit |

## Verification
The bench builds the block with an 8-bit register and taps 8'hB8. A state that short lets every scenario run over many groups of both sizes within a few hundred cycles. It therefore produces kept and discarded groups in both modes, a mode change at each position inside a group, and loads that arrive part-way through a group. A reference register stepped in the bench predicts every strobe and bit cycle by cycle. Zero-seed refusals and idle stretches are then checked by showing that the stream resumes exactly where it stopped.

// File: rtl/shrink_pkg.sv
// Shared types for the self-shrinking keystream generator.
package shrink_pkg;
    // Selection rule applied to one group of register bits
    typedef enum logic {
        SEL_PAIR   = 1'b0,   // two bits, first bit decides
        SEL_TRIPLE = 1'b1    // three bits, XOR of first two decides
    } sel_mode_t;

    // Position of the next consumed bit inside its group
    typedef enum logic [1:0] {
        POS_FIRST  = 2'd0,
        POS_SECOND = 2'd1,
        POS_THIRD  = 2'd2
    } grp_pos_t;
endpackage

// File: rtl/shrink_lfsr.sv
// Fibonacci shift register that supplies one bit per step.
// Assumes TAPS has its MSB set, so the step map is invertible and a
// nonzero state never reaches zero. A load with an all-zero seed is ignored.
module shrink_lfsr #(
    parameter int             LEN      = 16,
    parameter logic [LEN-1:0] TAPS     = 16'hB400,
    parameter logic [LEN-1:0] RST_SEED = 16'h0001
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN-1:0] seed,
    input  logic           step,
    output logic           cur_bit,
    output logic           load_ok
);
    logic [LEN-1:0] state;
    logic           fb;

    // Accept a load only when the seed is nonzero
    assign load_ok = load && (seed != '0);
    // Feedback bit is the parity of the tapped positions
    assign fb      = ^(state & TAPS);
    // Bit consumed by a step is the current MSB
    assign cur_bit = state[LEN-1];

    // State register: reset, accepted load, or one shift step
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= RST_SEED;
        else if (load_ok) state <= seed;
        else if (step)    state <= {state[LEN-2:0], fb};
    end

    // R1
    state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
    // R6
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> state == $past(seed));
    // R7
    zero_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0 && !step) |=> $stable(state));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(state));
endmodule

// File: rtl/shrink_decider.sv
// Groups consumed register bits and applies the selected keep rule.
// Assumes one bit arrives per step. The mode is latched with a group's
// first bit. clear restarts grouping and suppresses the strobe.
module shrink_decider
    import shrink_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic bit_in,
    input  logic mode_in,
    output logic ks_bit,
    output logic ks_valid
);
    grp_pos_t  pos;
    sel_mode_t gmode;
    logic      b0, b1;

    // Group tracking and registered keep decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos      <= POS_FIRST;
            gmode    <= SEL_PAIR;
            b0       <= 1'b0;
            b1       <= 1'b0;
            ks_bit   <= 1'b0;
            ks_valid <= 1'b0;
        end else begin
            ks_valid <= 1'b0;
            if (clear) begin
                pos <= POS_FIRST;
            end else if (step) begin
                case (pos)
                    POS_FIRST: begin
                        gmode <= sel_mode_t'(mode_in);
                        b0    <= bit_in;
                        pos   <= POS_SECOND;
                    end
                    POS_SECOND: begin
                        b1 <= bit_in;
                        if (gmode == SEL_PAIR) begin
                            ks_valid <= b0;
                            ks_bit   <= bit_in;
                            pos      <= POS_FIRST;
                        end else begin
                            pos <= POS_THIRD;
                        end
                    end
                    default: begin
                        ks_valid <= b0 ^ b1;
                        ks_bit   <= bit_in;
                        pos      <= POS_FIRST;
                    end
                endcase
            end
        end
    end

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |=> !ks_valid);
    // R4
    valid_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_valid |-> pos == POS_FIRST);
    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos != 2'd3);
    // R2
    pair_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode == SEL_PAIR) |-> pos != POS_THIRD);
    // R5
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != POS_FIRST && !clear) |=> $stable(gmode));
    // R6
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !ks_valid && pos == POS_FIRST);
endmodule

// File: rtl/shrink_keygen.sv
// Top level: single-register keystream generator with two- or three-bit
// selection groups and a valid strobe. A load takes priority over a step.
module shrink_keygen #(
    parameter int             LEN      = 16,
    parameter logic [LEN-1:0] TAPS     = 16'hB400,
    parameter logic [LEN-1:0] RST_SEED = 16'h0001
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           seed_load,
    input  logic [LEN-1:0] seed,
    input  logic           enable,
    input  logic           mode,
    output logic           ks_bit,
    output logic           ks_valid
);
    logic step;
    logic cur_bit;
    logic load_ok;

    // A load cycle (accepted or refused) never steps
    assign step = enable && !seed_load;

    shrink_lfsr #(.LEN(LEN), .TAPS(TAPS), .RST_SEED(RST_SEED)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load),
        .seed    (seed),
        .step    (step),
        .cur_bit (cur_bit),
        .load_ok (load_ok)
    );

    shrink_decider u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (load_ok),
        .step     (step),
        .bit_in   (cur_bit),
        .mode_in  (mode),
        .ks_bit   (ks_bit),
        .ks_valid (ks_valid)
    );

    // R7
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed == '0) |=> !ks_valid);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !seed_load) |=> !ks_valid);
endmodule

// File: tb/tb_shrink_keygen.sv
// Directed bench with a reference register model stepped from the requirements.
module tb_shrink_keygen;
    localparam int             L    = 8;
    localparam logic [L-1:0]   TP   = 8'hB8;
    localparam logic [L-1:0]   RSD  = 8'h01;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seed_load = 1'b0;
    logic [L-1:0] seed = '0;
    logic         enable = 1'b0;
    logic         mode = 1'b0;
    logic         ks_bit, ks_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [L-1:0] ms;
    int           mpos;
    logic         mmode, ma0, ma1, ev, eb;

    shrink_keygen #(.LEN(L), .TAPS(TP), .RST_SEED(RSD)) dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
        .enable(enable), .mode(mode), .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, advance model at posedge, compare at next negedge
    task automatic cyc(input bit en, input bit ld, input logic [L-1:0] sd,
                       input bit md, input string tag);
        logic b;
        enable = en; seed_load = ld; seed = sd; mode = md;
        @(posedge clk);
        ev = 1'b0;
        if (ld) begin
            if (sd != '0) begin ms = sd; mpos = 0; end
        end else if (en) begin
            b  = ms[L-1];
            ms = {ms[L-2:0], ^(ms & TP)};
            if (mpos == 0) begin
                mmode = md; ma0 = b; mpos = 1;
            end else if (mpos == 1) begin
                ma1 = b;
                if (!mmode) begin ev = ma0; eb = b; mpos = 0; end
                else mpos = 2;
            end else begin
                ev = ma0 ^ ma1; eb = b; mpos = 0;
            end
        end
        @(negedge clk);
        chk(ks_valid == ev, {tag, " valid"}, ks_valid, ev);
        if (ev) chk(ks_bit == eb, {tag, " bit"}, ks_bit, eb);
    endtask

    // R9: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ms = RSD; mpos = 0; mmode = 0; ma0 = 0; ma1 = 0; ev = 0; eb = 0;
        chk(ks_valid == 1'b0, "R9 valid after reset", ks_valid, 0);
        chk(ks_bit == 1'b0, "R9 bit after reset", ks_bit, 0);
        // R1 + R9: stream from the reset seed
        for (int i = 0; i < 12; i++) cyc(1, 0, '0, 0, "R9 R1 stream from reset seed");
    endtask

    // R2: pair mode over several seeds
    task automatic t_pair();
        cyc(0, 1, 8'hA5, 0, "R6 load");
        for (int i = 0; i < 60; i++) cyc(1, 0, '0, 0, "R2 R4 pair mode");
        cyc(0, 1, 8'h3C, 0, "R6 load");
        for (int i = 0; i < 60; i++) cyc(1, 0, '0, 0, "R2 R1 pair mode seed2");
    endtask

    // R3: triple mode
    task automatic t_triple();
        cyc(0, 1, 8'h5A, 1, "R6 load");
        for (int i = 0; i < 90; i++) cyc(1, 0, '0, 1, "R3 R4 triple mode");
    endtask

    // R5: mode toggled inside groups
    task automatic t_mode_mid();
        cyc(0, 1, 8'hC3, 1, "R6 load");
        for (int i = 0; i < 80; i++) cyc(1, 0, '0, (i % 5) < 2, "R5 mode mid-group");
    endtask

    // R6: load part-way through a group restarts grouping
    task automatic t_load_mid();
        cyc(0, 1, 8'h77, 1, "R6 load");
        cyc(1, 0, '0, 1, "R6 partial");
        cyc(1, 0, '0, 1, "R6 partial");
        cyc(1, 1, 8'h19, 1, "R6 load mid-group no strobe");
        for (int i = 0; i < 30; i++) cyc(1, 0, '0, 1, "R6 regroup after load");
    endtask

    // R7: zero seed refused, stream continues unchanged
    task automatic t_zero();
        cyc(0, 1, 8'h2E, 1, "R6 load");
        cyc(1, 0, '0, 1, "R7 partial");
        cyc(1, 1, '0, 1, "R7 zero seed refused");
        for (int i = 0; i < 30; i++) cyc(1, 0, '0, 1, "R7 stream resumes");
    endtask

    // R8: idle cycles hold everything
    task automatic t_idle();
        cyc(0, 1, 8'h81, 0, "R6 load");
        for (int i = 0; i < 40; i++) cyc((i % 3) != 1, 0, '0, 0, "R8 gaps in enable");
        for (int i = 0; i < 6; i++) cyc(0, 0, '0, 0, "R8 idle no strobe");
        for (int i = 0; i < 20; i++) cyc(1, 0, '0, 0, "R8 resume");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pair();
        t_triple();
        t_mode_mid();
        t_load_mid();
        t_zero();
        t_idle();
        done = 1'b1;
        summary();
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
        end
    end
endmodule